// File: doc/BRIEF.md
# Direct-Mapped Write-Through Word Cache

This block sits between a processor's load/store port and a slow, multi-cycle SDRAM controller. Each cache line holds exactly one data word. A line is chosen by the low bits of the word address, and the remaining high bits are kept as that line's tag. A read whose tag matches a valid line is answered from on-chip storage without touching memory. A read that misses fetches the word through the memory controller's enable/busy/ready handshake, hands it to the processor and installs it in the line.

Every processor write goes to memory and is also placed in the cache, so the two copies never disagree. A write always takes over its line, replacing whatever tag was there before. After reset, the block clears every line's valid bit with a sweep of one line per cycle. It accepts its first request only when that sweep has finished.

On the processor side the handshake works like this. The requester raises `cpu_req` together with its command and holds it until `cpu_done` pulses, then lowers it. The command fields are captured when the block accepts the request.

Top module: `wtc_cache`

## Requirements
- R1: After reset, `cpu_done`, `mem_rd_en` and `mem_wr_en` are low. The valid bits are cleared by a sweep that takes 2^IDX_W cycles, and no request completes before the sweep ends. After the sweep, every first read misses, whatever the stale tag storage holds.
- R2: The line index is `cpu_addr[IDX_W-1:0]` and the tag is `cpu_addr[ADDR_W-1:IDX_W]`. Addresses that differ only in index occupy separate lines.
- R3: A read that hits returns the stored word with `cpu_done` high on the second clock edge after `cpu_req` is first presented in idle. It raises no memory read.
- R4: A read miss raises `mem_rd_en` with `mem_addr` equal to the request address. It holds `mem_rd_en` until `mem_busy` is sampled high and lowers it on the following edge, so each miss costs exactly one memory read.
- R5: A read miss completes on the edge where `mem_rd_ready` is sampled high. `cpu_rdata` equals `mem_rd_data`, and the line is filled so that the next read of that address hits.
- R6: A write drives `mem_wr_en` with `mem_addr` and `mem_wdata` equal to the request. It holds `mem_wr_en` until `mem_busy` is sampled high, then lowers it. `cpu_done` pulses only after `mem_busy` has been sampled low again.
- R7: A write stores its data in the indexed line and sets that line's tag and valid bit. A following read of the same address hits, returns the written data and makes no memory read.
- R8: Two addresses with equal index and different tag evict each other. Alternating reads of them each cost one memory read.
- R9: `cpu_done` is a one-cycle pulse. A request is captured only in idle, and changes to `cpu_addr`, `cpu_we` or `cpu_wdata` while it is outstanding have no effect on its result.
- R10: `mem_rd_en` and `mem_wr_en` are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_req | input | 1 | Request, held until `cpu_done` |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | ADDR_W | Word address |
| cpu_wdata | input | DATA_W | Write data |
| cpu_rdata | output | DATA_W | Read data, valid with `cpu_done` |
| cpu_done | output | 1 | One-cycle completion pulse |
| mem_rd_en | output | 1 | Memory read enable |
| mem_wr_en | output | 1 | Memory write enable |
| mem_addr | output | ADDR_W | Memory word address |
| mem_wdata | output | DATA_W | Memory write data |
| mem_busy | input | 1 | Memory controller busy |
| mem_rd_ready | input | 1 | Memory read data valid pulse |
| mem_rd_data | input | DATA_W | Memory read data |

## Verification
The bench first reads every address of a small configuration in order, so that each index sees a new tag on every pass. A design that compared too few tag bits, or that ignored the valid bit after the reset sweep, would then report false hits, which show up as missing memory reads and wrong data. Repeated reads and read-after-write check for zero extra memory reads and a two-cycle hit latency, which catches a controller that refetches, or one that fails to allocate on a write. Alternating same-index reads, with the address changed mid-miss, expose a design that keeps the old tag or samples the command late. A model of the memory with variable latency catches enables held too long and writes that complete before busy falls.

// File: rtl/wtc_pkg.sv
package wtc_pkg;
    typedef enum logic [2:0] {
        ST_CLEAR,
        ST_IDLE,
        ST_LOOKUP,
        ST_READ_REQ,
        ST_READ_WAIT,
        ST_WRITE_REQ,
        ST_WRITE_WAIT
    } wtc_state_e;
endpackage

// File: rtl/wtc_sweep.sv
module wtc_sweep #(
    parameter int IDX_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    output logic             sweep_busy,
    output logic [IDX_W-1:0] sweep_idx
);
    localparam logic [IDX_W-1:0] LAST_IDX = {IDX_W{1'b1}};

    typedef struct packed {
        logic             run;
        logic [IDX_W-1:0] idx;
    } sweep_t;

    sweep_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (s_q.run) begin
            if (s_q.idx == LAST_IDX) begin
                s_d.run = 1'b0;
            end else begin
                s_d.idx = s_q.idx + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q.run <= 1'b1;
            s_q.idx <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign sweep_busy = s_q.run;
    assign sweep_idx  = s_q.idx;

    AST_SWEEP_ENDS_AT_LAST: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(s_q.run) |-> ($past(s_q.idx) == LAST_IDX)); // R1
endmodule

// File: rtl/wtc_line_store.sv
module wtc_line_store #(
    parameter int IDX_W  = 12,
    parameter int TAG_W  = 12,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic [IDX_W-1:0]  look_idx,
    input  logic [TAG_W-1:0]  look_tag,
    output logic              look_hit,
    output logic [DATA_W-1:0] look_data,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [TAG_W-1:0]  wr_tag,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              clr_en,
    input  logic [IDX_W-1:0]  clr_idx
);
    localparam int LINES = 1 << IDX_W;

    logic [DATA_W-1:0] data_mem  [LINES];
    logic [TAG_W-1:0]  tag_mem   [LINES];
    logic              valid_mem [LINES];

    always_ff @(posedge clk) begin
        if (clr_en) begin
            valid_mem[clr_idx] <= 1'b0;
        end else if (wr_en) begin
            valid_mem[wr_idx] <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (wr_en) begin
            data_mem[wr_idx] <= wr_data;
            tag_mem[wr_idx]  <= wr_tag;
        end
    end

    assign look_hit  = valid_mem[look_idx] && (tag_mem[look_idx] == look_tag);
    assign look_data = data_mem[look_idx];

    AST_NO_WRITE_DURING_CLEAR: assert property (@(posedge clk)
        clr_en |-> !wr_en); // R1
endmodule

// File: rtl/wtc_ctrl.sv
module wtc_ctrl
    import wtc_pkg::*;
#(
    parameter int ADDR_W = 24,
    parameter int IDX_W  = 12,
    parameter int DATA_W = 16
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    sweep_busy,
    input  logic                    cpu_req,
    input  logic                    cpu_we,
    input  logic [ADDR_W-1:0]       cpu_addr,
    input  logic [DATA_W-1:0]       cpu_wdata,
    output logic [DATA_W-1:0]       cpu_rdata,
    output logic                    cpu_done,
    input  logic                    hit_i,
    input  logic [DATA_W-1:0]       line_data_i,
    output logic [IDX_W-1:0]        look_idx,
    output logic [ADDR_W-IDX_W-1:0] look_tag,
    output logic                    store_we,
    output logic [DATA_W-1:0]       store_data,
    output logic                    mem_rd_en,
    output logic                    mem_wr_en,
    output logic [ADDR_W-1:0]       mem_addr,
    output logic [DATA_W-1:0]       mem_wdata,
    input  logic                    mem_busy,
    input  logic                    mem_rd_ready,
    input  logic [DATA_W-1:0]       mem_rd_data
);
    typedef struct packed {
        wtc_state_e        state;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] wdata;
        logic [DATA_W-1:0] rdata;
        logic              done;
        logic              rd_en;
        logic              wr_en;
    } ctrl_t;

    ctrl_t c_d, c_q;

    always_comb begin
        c_d      = c_q;
        c_d.done = 1'b0;
        unique case (c_q.state)
            ST_CLEAR: begin
                if (!sweep_busy) c_d.state = ST_IDLE;
            end
            ST_IDLE: begin
                if (cpu_req) begin
                    c_d.addr  = cpu_addr;
                    c_d.wdata = cpu_wdata;
                    if (cpu_we) begin
                        c_d.state = ST_WRITE_REQ;
                        c_d.wr_en = 1'b1;
                    end else begin
                        c_d.state = ST_LOOKUP;
                    end
                end
            end
            ST_LOOKUP: begin
                if (hit_i) begin
                    c_d.rdata = line_data_i;
                    c_d.done  = 1'b1;
                    c_d.state = ST_IDLE;
                end else begin
                    c_d.rd_en = 1'b1;
                    c_d.state = ST_READ_REQ;
                end
            end
            ST_READ_REQ: begin
                if (mem_busy) begin
                    c_d.rd_en = 1'b0;
                    c_d.state = ST_READ_WAIT;
                end
            end
            ST_READ_WAIT: begin
                if (mem_rd_ready) begin
                    c_d.rdata = mem_rd_data;
                    c_d.done  = 1'b1;
                    c_d.state = ST_IDLE;
                end
            end
            ST_WRITE_REQ: begin
                if (mem_busy) begin
                    c_d.wr_en = 1'b0;
                    c_d.state = ST_WRITE_WAIT;
                end
            end
            ST_WRITE_WAIT: begin
                if (!mem_busy) begin
                    c_d.done  = 1'b1;
                    c_d.state = ST_IDLE;
                end
            end
            default: c_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            c_q.state <= ST_CLEAR;
            c_q.addr  <= '0;
            c_q.wdata <= '0;
            c_q.rdata <= '0;
            c_q.done  <= 1'b0;
            c_q.rd_en <= 1'b0;
            c_q.wr_en <= 1'b0;
        end else begin
            c_q <= c_d;
        end
    end

    assign look_idx   = c_q.addr[IDX_W-1:0];
    assign look_tag   = c_q.addr[ADDR_W-1:IDX_W];
    assign store_we   = (c_q.state == ST_WRITE_REQ) ||
                        ((c_q.state == ST_READ_WAIT) && mem_rd_ready);
    assign store_data = (c_q.state == ST_WRITE_REQ) ? c_q.wdata : mem_rd_data;

    assign cpu_rdata = c_q.rdata;
    assign cpu_done  = c_q.done;
    assign mem_rd_en = c_q.rd_en;
    assign mem_wr_en = c_q.wr_en;
    assign mem_addr  = c_q.addr;
    assign mem_wdata = c_q.wdata;

    AST_ENABLES_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_rd_en && mem_wr_en)); // R10
    AST_DONE_SINGLE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_done |=> !cpu_done); // R9
    AST_RD_EN_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd_en && mem_busy) |=> !mem_rd_en); // R4
    AST_WR_EN_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_wr_en && mem_busy) |=> !mem_wr_en); // R6
    AST_NO_DONE_IN_SWEEP: assert property (@(posedge clk) disable iff (!rst_n)
        sweep_busy |-> !cpu_done); // R1
    AST_HIT_NO_FETCH: assert property (@(posedge clk) disable iff (!rst_n)
        (c_q.state == ST_LOOKUP && hit_i) |=> (cpu_done && !mem_rd_en)); // R3
    AST_ADDR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd_en || mem_wr_en) |=> $stable(mem_addr)); // R9
endmodule

// File: rtl/wtc_cache.sv
module wtc_cache #(
    parameter int ADDR_W = 24,
    parameter int IDX_W  = 12,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_req,
    input  logic              cpu_we,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [DATA_W-1:0] cpu_wdata,
    output logic [DATA_W-1:0] cpu_rdata,
    output logic              cpu_done,
    output logic              mem_rd_en,
    output logic              mem_wr_en,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic              mem_busy,
    input  logic              mem_rd_ready,
    input  logic [DATA_W-1:0] mem_rd_data
);
    localparam int TAG_W = ADDR_W - IDX_W;

    logic              sweep_busy;
    logic [IDX_W-1:0]  sweep_idx;
    logic              hit;
    logic [DATA_W-1:0] line_data;
    logic [IDX_W-1:0]  look_idx;
    logic [TAG_W-1:0]  look_tag;
    logic              store_we;
    logic [DATA_W-1:0] store_data;

    wtc_sweep #(.IDX_W(IDX_W)) u_sweep (
        .clk        (clk),
        .rst_n      (rst_n),
        .sweep_busy (sweep_busy),
        .sweep_idx  (sweep_idx)
    );

    wtc_line_store #(.IDX_W(IDX_W), .TAG_W(TAG_W), .DATA_W(DATA_W)) u_store (
        .clk       (clk),
        .look_idx  (look_idx),
        .look_tag  (look_tag),
        .look_hit  (hit),
        .look_data (line_data),
        .wr_en     (store_we),
        .wr_idx    (look_idx),
        .wr_tag    (look_tag),
        .wr_data   (store_data),
        .clr_en    (sweep_busy),
        .clr_idx   (sweep_idx)
    );

    wtc_ctrl #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .DATA_W(DATA_W)) u_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .sweep_busy   (sweep_busy),
        .cpu_req      (cpu_req),
        .cpu_we       (cpu_we),
        .cpu_addr     (cpu_addr),
        .cpu_wdata    (cpu_wdata),
        .cpu_rdata    (cpu_rdata),
        .cpu_done     (cpu_done),
        .hit_i        (hit),
        .line_data_i  (line_data),
        .look_idx     (look_idx),
        .look_tag     (look_tag),
        .store_we     (store_we),
        .store_data   (store_data),
        .mem_rd_en    (mem_rd_en),
        .mem_wr_en    (mem_wr_en),
        .mem_addr     (mem_addr),
        .mem_wdata    (mem_wdata),
        .mem_busy     (mem_busy),
        .mem_rd_ready (mem_rd_ready),
        .mem_rd_data  (mem_rd_data)
    );
endmodule

// File: tb/sim_wtc_cache.sv
module sim_wtc_cache;
    localparam int CLK_PERIOD = 10;
    localparam int ADDR_W = 8;
    localparam int IDX_W  = 4;
    localparam int DATA_W = 16;
    localparam int LINES  = 1 << IDX_W;
    localparam int WORDS  = 1 << ADDR_W;
    localparam int WDOG   = 150000;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              cpu_req = 1'b0;
    logic              cpu_we = 1'b0;
    logic [ADDR_W-1:0] cpu_addr = '0;
    logic [DATA_W-1:0] cpu_wdata = '0;
    logic [DATA_W-1:0] cpu_rdata;
    logic              cpu_done;
    logic              mem_rd_en, mem_wr_en;
    logic [ADDR_W-1:0] mem_addr;
    logic [DATA_W-1:0] mem_wdata;
    logic              mem_busy = 1'b0;
    logic              mem_rd_ready = 1'b0;
    logic [DATA_W-1:0] mem_rd_data = '0;

    wtc_cache #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .DATA_W(DATA_W)) u0 (
        .clk(clk), .rst_n(rst_n), .cpu_req(cpu_req), .cpu_we(cpu_we),
        .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata),
        .cpu_done(cpu_done), .mem_rd_en(mem_rd_en), .mem_wr_en(mem_wr_en),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_busy(mem_busy),
        .mem_rd_ready(mem_rd_ready), .mem_rd_data(mem_rd_data)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [DATA_W-1:0] init_word(int a);
        return DATA_W'((a * 40503 + 4660) ^ 23130);
    endfunction

    function automatic logic [DATA_W-1:0] new_word(int a);
        return DATA_W'(a * 257 + 48879);
    endfunction

    // memory model with variable latency
    logic [DATA_W-1:0] mem [WORDS];
    logic [ADDR_W-1:0] m_addr = '0;
    logic              m_pend_rd = 1'b0;
    int                m_cnt = 0;
    int                reads = 0;
    int                both_high = 0;

    initial begin
        for (int a = 0; a < WORDS; a++) mem[a] = init_word(a);
    end

    always @(posedge clk) begin
        if (!rst_n) begin
            mem_busy     <= 1'b0;
            mem_rd_ready <= 1'b0;
            m_cnt        <= 0;
        end else begin
            mem_rd_ready <= 1'b0;
            if (mem_busy) begin
                if (m_cnt == 0) begin
                    mem_busy <= 1'b0;
                    if (m_pend_rd) begin
                        mem_rd_ready <= 1'b1;
                        mem_rd_data  <= mem[m_addr];
                    end
                end else begin
                    m_cnt <= m_cnt - 1;
                end
            end else if (!mem_rd_ready && mem_rd_en) begin
                mem_busy  <= 1'b1;
                m_pend_rd <= 1'b1;
                m_addr    <= mem_addr;
                m_cnt     <= 2 + int'(mem_addr[1:0]);
                reads     <= reads + 1;
            end else if (!mem_rd_ready && mem_wr_en) begin
                mem_busy      <= 1'b1;
                m_pend_rd     <= 1'b0;
                mem[mem_addr] <= mem_wdata;
                m_cnt         <= 1 + int'(mem_addr[1:0]);
            end
        end
    end

    always @(negedge clk) begin
        if (rst_n && mem_rd_en && mem_wr_en) both_high <= both_high + 1;
    end

    int n_chk = 0;
    int n_fail = 0;
    logic [DATA_W-1:0] ref_mem [WORDS];

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    endtask

    // one request; perturb changes the command fields while outstanding
    task automatic do_op(input bit we, input int a, input logic [DATA_W-1:0] wd,
                         input bit perturb, output logic [DATA_W-1:0] rd,
                         output int lat, output bit busy_seen, output bit busy_at_done);
        @(negedge clk);
        cpu_req   = 1'b1;
        cpu_we    = we;
        cpu_addr  = ADDR_W'(a);
        cpu_wdata = wd;
        lat = 0;
        busy_seen = 1'b0;
        forever begin
            @(negedge clk);
            lat++;
            if (mem_busy) busy_seen = 1'b1;
            if (perturb && lat == 3) begin
                cpu_addr  = ~ADDR_W'(a);
                cpu_we    = ~we;
                cpu_wdata = ~wd;
            end
            if (cpu_done) break;
        end
        rd = cpu_rdata;
        busy_at_done = mem_busy;
        cpu_req = 1'b0;
        cpu_we  = 1'b0;
        @(negedge clk);
        chk(!cpu_done, "R9 done width", int'(cpu_done), 0);
    endtask

    task automatic rd_check(input int a, input int exp_reads, input bit perturb,
                            input string req);
        logic [DATA_W-1:0] rd;
        int lat, r0;
        bit bs, bd;
        r0 = reads;
        do_op(1'b0, a, '0, perturb, rd, lat, bs, bd);
        chk(rd == ref_mem[a], req, int'(rd), int'(ref_mem[a]));
        chk(reads - r0 == exp_reads, {req, " mem reads"}, reads - r0, exp_reads);
        if (exp_reads == 0) chk(lat == 2, "R3 hit latency", lat, 2);
    endtask

    initial begin
        logic [DATA_W-1:0] rd;
        int lat, r0;
        bit bs, bd;
        for (int a = 0; a < WORDS; a++) ref_mem[a] = init_word(a);
        repeat (3) @(negedge clk);
        chk(!cpu_done && !mem_rd_en && !mem_wr_en, "R1 reset outputs",
            int'({cpu_done, mem_rd_en, mem_wr_en}), 0);
        rst_n = 1'b1;
        // first request held across the clear sweep; tag 0 stale content must miss
        r0 = reads;
        do_op(1'b0, 0, '0, 1'b0, rd, lat, bs, bd);
        chk(lat > LINES, "R1 sweep delays service", lat, LINES + 1);
        chk(reads - r0 == 1, "R1 first read misses", reads - r0, 1);
        chk(rd == ref_mem[0], "R5 first read data", int'(rd), int'(ref_mem[0]));
        // every address in order: each index sees a new tag every time
        for (int a = 1; a < WORDS; a++) rd_check(a, 1, 1'b0, "R5 sequential miss");
        // lines 0..15 now hold the top tag; refill then all hit (R2 distinct lines)
        for (int a = 0; a < LINES; a++) rd_check(a, 1, 1'b0, "R5 refill");
        for (int a = 0; a < LINES; a++) rd_check(a, 0, 1'b0, "R2 R3 hit");
        // write-through with allocate
        for (int a = 2 * LINES; a < 3 * LINES; a++) begin
            ref_mem[a] = new_word(a);
            r0 = reads;
            do_op(1'b1, a, new_word(a), 1'b0, rd, lat, bs, bd);
            chk(bs && !bd, "R6 done after busy falls", int'({bs, bd}), 2);
            chk(reads - r0 == 0, "R6 write makes no read", reads - r0, 0);
        end
        for (int a = 2 * LINES; a < 3 * LINES; a++) begin
            chk(mem[a] == new_word(a), "R6 memory updated", int'(mem[a]), int'(new_word(a)));
            rd_check(a, 0, 1'b0, "R7 read after write");
        end
        // same-index eviction, command fields disturbed mid-miss
        for (int i = 0; i < LINES; i++) begin
            rd_check(5 * LINES + i, 1, 1'b1, "R8 R9 evict A");
            rd_check(10 * LINES + i, 1, 1'b1, "R8 R9 evict B");
            rd_check(5 * LINES + i, 1, 1'b0, "R8 evict A again");
        end
        // a write evicts a line of another tag at the same index
        do_op(1'b1, 7 * LINES + 3, 16'h1234, 1'b0, rd, lat, bs, bd);
        ref_mem[7 * LINES + 3] = 16'h1234;
        rd_check(7 * LINES + 3, 0, 1'b0, "R7 write allocates over other tag");
        rd_check(5 * LINES + 3, 1, 1'b0, "R7 write evicted old tag");
        chk(both_high == 0, "R10 enables exclusive", both_high, 0);
        finish_run();
    end

    initial begin
        for (int c = 0; c < WDOG; c++) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual %0d expected %0d", WDOG, 0);
        finish_run();
    end
endmodule